// File: doc/BRIEF.md
# I2C Slave Register-Access Controller

This block lets an external I2C master read and write an internal bank of 8-bit registers. It samples the bus clock and data lines with a fast system clock, recognises START, repeated START and STOP, and answers to one 7-bit device address. The five upper address bits are fixed. The two lower bits come from a strap input that is captured once after reset, so four devices can share a bus.

A write transaction carries the device address with the direction bit clear, then one register-pointer byte, then any number of data bytes. Each data byte appears at the register port as a single-cycle write strobe. A read first sets the pointer with a write, then issues a repeated START and the device address with the direction bit set. The block then returns register contents MSB first until the master answers with NACK. When auto-increment is enabled, the pointer steps by one after each data byte. When it is disabled, the pointer holds its value.

The block only ever pulls SDA low through an open-drain enable and never drives SCL. The register bank is outside the block. It returns read data combinationally for the address shown on the register port.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0, `reg_we_o` is 0 and `reg_addr_o` is 0x00.
- R2: An address byte whose upper seven bits equal {5'b11010, captured strap} is acknowledged (SDA held low during the ninth clock). Any other address is not acknowledged, and the bytes that follow until the next START cause no register write and no acknowledge.
- R3: The strap value is captured on the first clock after reset is released. Later changes on `strap_i` have no effect on the address the block answers to.
- R4: In a write, the byte after the address loads the pointer. Each further byte gives exactly one single-cycle `reg_we_o` pulse, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte. Every received byte is acknowledged. No write strobe occurs while the direction bit is set (bit 0 of the address byte, 1 = read).
- R5: After a repeated START with the read bit, the block sends the register at the pointer MSB first on SDA, one bit per SCL low phase.
- R6: With `autoinc_i` high, the pointer increments by one, modulo 256, during the acknowledge clock of every data byte, whether read or written. Consecutive bytes therefore address consecutive registers, and the pointer wraps from 0xFF to 0x00.
- R7: With `autoinc_i` low, the pointer changes only when a register-pointer byte is received. Repeated data bytes all use the same register.
- R8: When the master NACKs a read byte, the block releases SDA. It drives nothing more until the next START.
- R9: `sda_oe_o` changes only while SCL is low.
- R10: The pointer is kept across STOP. A read issued without a pointer byte starts at the retained pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 10x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 2 | Low address bits, captured after reset |
| autoinc_i | input | 1 | Pointer auto-increment enable |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (wired level) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | 8 | Register pointer |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o` |

## Verification
The bench builds the block with its default parameters: fixed prefix 11010, two synchroniser stages, and 8-bit pointer and data. The strap is set to 10 through reset and then moved to 01. This shows that the captured value, and not the live pin, decides the match. The 8-bit pointer is narrow enough that a two-byte burst at 0xFF reaches the wrap to 0x00. A following pointer-less read then shows the retained value after STOP.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } xfer_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  // bus idles high, so the pipes reset to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[SYNC_STAGES-1];
      sda_prev <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[SYNC_STAGES-1];
  assign sda_o      = sda_pipe[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/i2c_strap_latch.sv
module i2c_strap_latch #(
  parameter int STRAP_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [STRAP_W-1:0] strap_o
);
  logic taken_q;

  // one-shot capture on the first clock after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= 1'b0;
      strap_o <= '0;
    end else if (!taken_q) begin
      taken_q <= 1'b1;
      strap_o <= strap_i;
    end
  end
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
  import i2c_reg_pkg::*;
#(
  parameter int             PREFIX_W = 5,
  parameter logic [PREFIX_W-1:0] PREFIX = 5'b11010,
  parameter int             STRAP_W  = 7 - PREFIX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sda_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               autoinc_i,
  input  logic [BYTE_W-1:0]  rdata_i,
  output logic               sda_oe_o,
  output logic [BYTE_W-1:0]  ptr_o,
  output logic [BYTE_W-1:0]  wdata_o,
  output logic               we_o,
  output logic               ptr_ld_o,
  output logic               rw_o,
  output logic               idle_o
);
  xfer_st_e st_q;
  logic [BYTE_W-1:0] shreg_q, tx_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic              nack_q;
  logic              byte_done, addr_hit;

  assign byte_done = scl_fall_i && (bitcnt_q == CNT_W'(BYTE_W));
  assign addr_hit  = (shreg_q[BYTE_W-1:1] == {PREFIX, strap_i});
  assign idle_o    = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      shreg_q  <= '0;
      tx_q     <= '0;
      bitcnt_q <= '0;
      nack_q   <= 1'b0;
      rw_o     <= 1'b0;
      ptr_o    <= '0;
      wdata_o  <= '0;
      we_o     <= 1'b0;
      ptr_ld_o <= 1'b0;
      sda_oe_o <= 1'b0;
    end else begin
      we_o     <= 1'b0;
      ptr_ld_o <= 1'b0;
      if (start_i) begin
        st_q     <= ST_ADDR;
        bitcnt_q <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_REG, ST_WDATA: begin
            if (scl_rise_i) begin
              shreg_q  <= {shreg_q[BYTE_W-2:0], sda_i};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (byte_done) begin
              bitcnt_q <= '0;
              if (st_q == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe_o <= 1'b1;
                  rw_o     <= shreg_q[0];
                  st_q     <= ST_ADDR_ACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else if (st_q == ST_REG) begin
                ptr_o    <= shreg_q;
                ptr_ld_o <= 1'b1;
                sda_oe_o <= 1'b1;
                st_q     <= ST_REG_ACK;
              end else begin
                we_o     <= 1'b1;
                wdata_o  <= shreg_q;
                sda_oe_o <= 1'b1;
                st_q     <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              bitcnt_q <= '0;
              if (rw_o) begin
                tx_q     <= rdata_i;
                sda_oe_o <= ~rdata_i[BYTE_W-1];
                st_q     <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_REG;
              end
            end
          end
          ST_REG_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_rise_i && autoinc_i) ptr_o <= ptr_o + 1'b1;
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall_i) begin
              if (bitcnt_q == CNT_W'(BYTE_W - 1)) begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_RDATA_ACK;
              end else begin
                tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~tx_q[BYTE_W-2];
                bitcnt_q <= bitcnt_q + 1'b1;
              end
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise_i) begin
              nack_q <= sda_i;
              if (autoinc_i) ptr_o <= ptr_o + 1'b1;
            end
            // pointer settled at the rise; bank data is ready by the fall
            if (scl_fall_i) begin
              bitcnt_q <= '0;
              if (nack_q) begin
                st_q <= ST_IDLE;
              end else begin
                tx_q     <= rdata_i;
                sda_oe_o <= ~rdata_i[BYTE_W-1];
                st_q     <= ST_RDATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter int                  SYNC_STAGES = 2,
  parameter int                  PREFIX_W    = 5,
  parameter logic [PREFIX_W-1:0] PREFIX      = 5'b11010,
  localparam int                 STRAP_W     = 7 - PREFIX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               autoinc_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [BYTE_W-1:0]  reg_addr_o,
  output logic [BYTE_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  input  logic [BYTE_W-1:0]  reg_rdata_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic [STRAP_W-1:0] strap_q;
  logic ptr_ld, rw_q, fsm_idle;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  i2c_strap_latch #(.STRAP_W(STRAP_W)) u_strap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (strap_i),
    .strap_o (strap_q)
  );

  i2c_xfer_fsm #(
    .PREFIX_W (PREFIX_W),
    .PREFIX   (PREFIX),
    .STRAP_W  (STRAP_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .strap_i    (strap_q),
    .autoinc_i  (autoinc_i),
    .rdata_i    (reg_rdata_i),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .we_o       (reg_we_o),
    .ptr_ld_o   (ptr_ld),
    .rw_o       (rw_q),
    .idle_o     (fsm_idle)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       sda_oe_o,
  input logic       reg_we_o,
  input logic [7:0] reg_addr_o,
  input logic       autoinc_i,
  input logic       ptr_ld,
  input logic       rw_q,
  input logic       fsm_idle
);
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s); // R9

  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R4

  AST_WE_NOT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !rw_q); // R4

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_addr_o != $past(reg_addr_o)) && !ptr_ld) |-> (reg_addr_o == $past(reg_addr_o) + 8'd1)); // R6

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!autoinc_i) && !ptr_ld) |-> $stable(reg_addr_o)); // R7

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsm_idle |-> !sda_oe_o); // R8
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .sda_oe_o   (sda_oe_o),
  .reg_we_o   (reg_we_o),
  .reg_addr_o (reg_addr_o),
  .autoinc_i  (autoinc_i),
  .ptr_ld     (ptr_ld),
  .rw_q       (rw_q),
  .fsm_idle   (fsm_idle)
);

// File: tb/i2c_reg_slave_test.sv
module i2c_reg_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int QTR  = 6;
  localparam int HIGH = 12;
  localparam logic [6:0] DEV = 7'h6A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] strap = 2'b10;
  logic autoinc = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic reg_we;

  logic [7:0] bank [256];
  logic [7:0] exp_bank [256];
  logic [15:0] exp_q [$];
  int checks = 0, failures = 0;
  int model_ptr = 0;
  logic prev_oe = 1'b0, scl_at_edge = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = bank[reg_addr];

  i2c_reg_slave uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .strap_i     (strap),
    .autoinc_i   (autoinc),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sda_oe_o    (sda_oe),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_rdata_i (reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      bank[i]     = 8'(i ^ 8'h5C);
      exp_bank[i] = 8'(i ^ 8'h5C);
    end
  end

  always @(posedge clk) begin
    if (reg_we) bank[reg_addr] <= reg_wdata;
    scl_at_edge <= scl_m;
  end

  // per-clock comparison against the bench model
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe !== prev_oe) chk(!scl_at_edge, "R9 oe change with SCL high", 1, 0);
      if (reg_we) begin
        if (exp_q.size() == 0) chk(1'b0, "R2/R4 unexpected write", {reg_addr, reg_wdata}, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({reg_addr, reg_wdata} == e, "R4 write addr/data", {reg_addr, reg_wdata}, e);
        end
      end
    end
    prev_oe = sda_oe;
  end

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; waitc(QTR);
    scl_m = 1'b1; waitc(QTR);
    sda_m = 1'b0; waitc(QTR);
    scl_m = 1'b0; waitc(QTR);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; waitc(QTR);
    scl_m = 1'b1; waitc(QTR);
    sda_m = 1'b1; waitc(HIGH);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitc(QTR);
      scl_m = 1'b1; waitc(HIGH);
      scl_m = 1'b0; waitc(QTR);
    end
    sda_m = 1'b1; waitc(QTR);
    scl_m = 1'b1; waitc(HIGH/2);
    ack = !sda_line; waitc(HIGH/2);
    scl_m = 1'b0; waitc(QTR);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitc(QTR);
      scl_m = 1'b1; waitc(HIGH/2);
      b[i] = sda_line; waitc(HIGH/2);
      scl_m = 1'b0; waitc(QTR);
    end
    sda_m = !give_ack; waitc(QTR);
    scl_m = 1'b1; waitc(HIGH);
    scl_m = 1'b0; waitc(QTR);
    sda_m = 1'b1;
  endtask

  task automatic write_regs(input logic [7:0] ra, input logic [7:0] d [$]);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R2 address ack", ack, 1);
    send_byte(ra, ack);          chk(ack, "R4 pointer ack", ack, 1);
    model_ptr = ra;
    foreach (d[k]) begin
      exp_q.push_back({8'(model_ptr), d[k]});
      exp_bank[model_ptr] = d[k];
      send_byte(d[k], ack); chk(ack, "R4 data ack", ack, 1);
      if (autoinc) model_ptr = (model_ptr + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic read_regs(input bit set_ptr, input logic [7:0] ra, input int n, input string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    if (set_ptr) begin
      send_byte({DEV, 1'b0}, ack); chk(ack, "R2 address ack", ack, 1);
      send_byte(ra, ack);          chk(ack, "R4 pointer ack", ack, 1);
      model_ptr = ra;
      bus_start(); // repeated START
    end
    send_byte({DEV, 1'b1}, ack); chk(ack, "R5 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(b, k != n - 1);
      chk(b == exp_bank[model_ptr], req, b, exp_bank[model_ptr]);
      if (autoinc) model_ptr = (model_ptr + 1) % 256;
    end
    waitc(4);
    chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
    recv_byte(b, 1'b0);
    chk(b == 8'hFF, "R8 silent after NACK", b, 8'hFF);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] q [$];
    waitc(5);
    rst_n = 1'b1;
    waitc(3);
    // R1
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(reg_we == 1'b0, "R1 we after reset", reg_we, 0);
    chk(reg_addr == 8'h00, "R1 pointer after reset", reg_addr, 0);
    strap = 2'b01; // R3: must be ignored from now on

    // R2: wrong low bit, no ack, following byte ignored
    bus_start();
    send_byte({7'h6B, 1'b0}, ack); chk(!ack, "R2 mismatch nack", ack, 0);
    send_byte(8'h33, ack);         chk(!ack, "R2 ignored byte nack", ack, 0);
    bus_stop();

    // R3: address from the live strap is not answered
    bus_start();
    send_byte({7'h69, 1'b0}, ack); chk(!ack, "R3 live strap nack", ack, 0);
    bus_stop();

    // R4/R6 burst write, R5/R6 burst read
    autoinc = 1'b1;
    q = '{8'hA1, 8'hB2, 8'hC3};
    write_regs(8'h10, q);
    read_regs(1'b1, 8'h10, 3, "R5 R6 burst read data");

    // R7 pointer holds
    autoinc = 1'b0;
    q = '{8'h5A, 8'h6B};
    write_regs(8'h20, q);
    read_regs(1'b1, 8'h21, 1, "R7 neighbour untouched");
    read_regs(1'b1, 8'h20, 2, "R7 repeated register read");

    // R6 wrap at 0xFF
    autoinc = 1'b1;
    q = '{8'h11, 8'h22};
    write_regs(8'hFF, q);
    read_regs(1'b1, 8'hFF, 2, "R6 wrap read data");

    // R10 pointer kept across STOP
    read_regs(1'b0, 8'h00, 1, "R10 retained pointer read");

    waitc(20);
    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule